// File: doc/BRIEF.md
# Trap and Interrupt Vectoring Unit

This unit sits beside the execute stage of a 32-bit processor. It decides what happens when normal flow must stop. The candidates are reset, a hardware exception, a hardware or software break, an external interrupt and a user trap. When more than one of these asks for service in the same cycle, the unit picks one by fixed rank.

The chosen event has several effects:
- The program counter is sent to that event's fixed vector, and a flush pulse goes to the front end.
- The return address is written to the general register reserved for that event class.
- The machine status register is updated, and so are the exception status, exception address, floating-point status and branch target registers where the event calls for it.

The pipeline supplies the current PC, whether the instruction is in a branch delay slot, the pending branch target, an exception cause and detail code, and a faulting address. The pipeline can also load the machine status register when no event is taken. Handler return instructions belong to the decoder and are not handled here.

Every response is registered. Whatever is sampled at one clock edge shows up on the outputs right after that edge.

Top module: `trap_vector_unit`

## Requirements
- R1: While `rst` is high at an edge, the unit does the following after that edge: `flush`=1, `newPc`=0, `msr`=RESET_MSR (default 0x00000102), and `esr`, `ear`, `fsr` and `btr` are all 0.
- R2: Simultaneous requests are ranked reset > exception > break > interrupt > user trap. Only the highest-ranked request that is eligible is taken.
- R3: A user trap redirects to 0x08. It writes `curPc` into the general register indexed by `trapReg`.
- R4: An accepted interrupt redirects to 0x10, writes `curPc` into register 14 and clears msr bit 1 (interrupt enable).
- R5: An interrupt is accepted only if msr bit 1 is set and msr bits 3 (break in progress) and 9 (exception in progress) are clear. Otherwise it is ignored: no flush, and any lower-ranked request is taken instead.
- R6: A break redirects to 0x18, writes `curPc` into register 16 and sets msr bit 3.
- R7: An exception redirects to 0x20, clears msr bit 8 (exception enable) and sets msr bit 9.
- R8: An exception loads `esr` with the cause in bits [4:0], the detail in bits [11:5] and the delay-slot flag in bit 12, with zeros above. It also loads `ear` from `excAddr` and `fsr` from `excFsr`.
- R9: An exception raised in a delay slot loads `btr` from `branchTarget` and writes no general register.
- R10: An exception outside a delay slot writes `curPc`+4 into register 17 and leaves `btr` unchanged.
- R11: `flush` is high for exactly one cycle per redirect. `gprWe` is never high without `flush`. A cycle with no event changes no special register.
- R12: `msrLd` copies `msrLdVal` into `msr` only in a cycle where no event is taken. In a cycle where an event is taken, the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset event, active high |
| excReq | input | 1 | Hardware exception request |
| brkReq | input | 1 | Break request (hardware or software) |
| irqReq | input | 1 | External interrupt request |
| trapReq | input | 1 | User-vector trap request |
| inDelaySlot | input | 1 | Current instruction sits in a branch delay slot |
| curPc | input | 32 | PC of the current instruction |
| branchTarget | input | 32 | Target of the branch owning the delay slot |
| excCause | input | 5 | Exception cause code |
| excDetail | input | 7 | Cause-specific detail field |
| excAddr | input | 32 | Exception address value |
| excFsr | input | 5 | Floating-point status value for the exception |
| trapReg | input | 5 | Register index for the user-trap return address |
| msrLd | input | 1 | Load machine status register from pipeline |
| msrLdVal | input | 32 | Value for that load |
| flush | output | 1 | One-cycle redirect pulse |
| newPc | output | 32 | Redirect target |
| gprWe | output | 1 | General register write enable |
| gprAddr | output | 5 | General register index |
| gprData | output | 32 | Return address written |
| msr | output | 32 | Machine status register |
| esr | output | 32 | Exception status register |
| ear | output | 32 | Exception address register |
| btr | output | 32 | Branch target register |
| fsr | output | 5 | Floating-point status register |

## Verification
The arbitration depends on the status bits held inside the unit, so those bits are the main risk. A stale or wrongly set interrupt-enable, break-in-progress or exception-in-progress bit shows up on `msr` one cycle after the event that changed it. It then shows up again on the next interrupt request, which either fails to produce a `flush` or produces one when it should not. A wrong rank or a wrong field packing shows on `newPc`, `gprAddr`, `esr` or `btr` on the cycle right after the request edge.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef struct packed {
    logic doRst;
    logic doExc;
    logic doBrk;
    logic doIrq;
    logic doTrap;
    logic doMsrLd;
  } trapStrobes_t;

  localparam int unsigned VEC_RESET = 32'h0000_0000;
  localparam int unsigned VEC_TRAP  = 32'h0000_0008;
  localparam int unsigned VEC_IRQ   = 32'h0000_0010;
  localparam int unsigned VEC_BRK   = 32'h0000_0018;
  localparam int unsigned VEC_EXC   = 32'h0000_0020;

  localparam int unsigned LINK_IRQ = 14;
  localparam int unsigned LINK_BRK = 16;
  localparam int unsigned LINK_EXC = 17;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic         rst,
  input  logic         excReq,
  input  logic         brkReq,
  input  logic         irqReq,
  input  logic         trapReq,
  input  logic         msrLd,
  input  logic         msrIe,
  input  logic         msrBip,
  input  logic         msrEip,
  output trapStrobes_t strobe
);

  logic irqOk;

  always_comb irqOk = irqReq && msrIe && !msrBip && !msrEip;

  always_comb begin
    strobe = '0;
    if (rst)              strobe.doRst   = 1'b1;
    else if (excReq)      strobe.doExc   = 1'b1;
    else if (brkReq)      strobe.doBrk   = 1'b1;
    else if (irqOk)       strobe.doIrq   = 1'b1;
    else if (trapReq)     strobe.doTrap  = 1'b1;
    else if (msrLd)       strobe.doMsrLd = 1'b1;
  end

endmodule

// File: rtl/trap_dpath.sv
module trap_dpath
  import trap_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_IDX   = 5,
  parameter int unsigned CAUSE_W   = 5,
  parameter int unsigned DETAIL_W  = 7,
  parameter int unsigned FSR_W     = 5,
  parameter logic [XLEN-1:0] RESET_MSR = 'h102,
  parameter int unsigned IE_BIT    = 1,
  parameter int unsigned BIP_BIT   = 3,
  parameter int unsigned EE_BIT    = 8,
  parameter int unsigned EIP_BIT   = 9
)(
  input  logic                clk,
  input  trapStrobes_t        strobe,
  input  logic                inDelaySlot,
  input  logic [XLEN-1:0]     curPc,
  input  logic [XLEN-1:0]     branchTarget,
  input  logic [CAUSE_W-1:0]  excCause,
  input  logic [DETAIL_W-1:0] excDetail,
  input  logic [XLEN-1:0]     excAddr,
  input  logic [FSR_W-1:0]    excFsr,
  input  logic [REG_IDX-1:0]  trapReg,
  input  logic [XLEN-1:0]     msrLdVal,
  output logic                flush,
  output logic [XLEN-1:0]     newPc,
  output logic                gprWe,
  output logic [REG_IDX-1:0]  gprAddr,
  output logic [XLEN-1:0]     gprData,
  output logic [XLEN-1:0]     msr,
  output logic [XLEN-1:0]     esr,
  output logic [XLEN-1:0]     ear,
  output logic [XLEN-1:0]     btr,
  output logic [FSR_W-1:0]    fsr
);

  localparam int unsigned DS_POS    = CAUSE_W + DETAIL_W;
  localparam int unsigned ESR_USED  = DS_POS + 1;
  localparam int unsigned ESR_SPARE = XLEN - ESR_USED;

  logic [XLEN-1:0] esrNext;
  logic [XLEN-1:0] pcPlus4;

  generate
    if (ESR_SPARE > 0) begin : g_esrPad
      always_comb esrNext = {{ESR_SPARE{1'b0}}, inDelaySlot, excDetail, excCause};
    end else begin : g_esrFull
      always_comb esrNext = {inDelaySlot, excDetail, excCause};
    end
  endgenerate

  always_comb pcPlus4 = curPc + XLEN'(4);

  always_ff @(posedge clk) begin
    flush <= 1'b0;
    gprWe <= 1'b0;
    if (strobe.doRst) begin
      flush <= 1'b1;
      newPc <= XLEN'(VEC_RESET);
      msr   <= RESET_MSR;
      esr   <= '0;
      ear   <= '0;
      fsr   <= '0;
      btr   <= '0;
    end else if (strobe.doExc) begin
      flush        <= 1'b1;
      newPc        <= XLEN'(VEC_EXC);
      msr[EE_BIT]  <= 1'b0;
      msr[EIP_BIT] <= 1'b1;
      esr          <= esrNext;
      ear          <= excAddr;
      fsr          <= excFsr;
      if (inDelaySlot) begin
        btr <= branchTarget;
      end else begin
        gprWe   <= 1'b1;
        gprAddr <= REG_IDX'(LINK_EXC);
        gprData <= pcPlus4;
      end
    end else if (strobe.doBrk) begin
      flush        <= 1'b1;
      newPc        <= XLEN'(VEC_BRK);
      msr[BIP_BIT] <= 1'b1;
      gprWe        <= 1'b1;
      gprAddr      <= REG_IDX'(LINK_BRK);
      gprData      <= curPc;
    end else if (strobe.doIrq) begin
      flush       <= 1'b1;
      newPc       <= XLEN'(VEC_IRQ);
      msr[IE_BIT] <= 1'b0;
      gprWe       <= 1'b1;
      gprAddr     <= REG_IDX'(LINK_IRQ);
      gprData     <= curPc;
    end else if (strobe.doTrap) begin
      flush   <= 1'b1;
      newPc   <= XLEN'(VEC_TRAP);
      gprWe   <= 1'b1;
      gprAddr <= trapReg;
      gprData <= curPc;
    end else if (strobe.doMsrLd) begin
      msr <= msrLdVal;
    end
  end

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_IDX   = 5,
  parameter int unsigned CAUSE_W   = 5,
  parameter int unsigned DETAIL_W  = 7,
  parameter int unsigned FSR_W     = 5,
  parameter logic [XLEN-1:0] RESET_MSR = 'h102,
  parameter int unsigned IE_BIT    = 1,
  parameter int unsigned BIP_BIT   = 3,
  parameter int unsigned EE_BIT    = 8,
  parameter int unsigned EIP_BIT   = 9
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                excReq,
  input  logic                brkReq,
  input  logic                irqReq,
  input  logic                trapReq,
  input  logic                inDelaySlot,
  input  logic [XLEN-1:0]     curPc,
  input  logic [XLEN-1:0]     branchTarget,
  input  logic [CAUSE_W-1:0]  excCause,
  input  logic [DETAIL_W-1:0] excDetail,
  input  logic [XLEN-1:0]     excAddr,
  input  logic [FSR_W-1:0]    excFsr,
  input  logic [REG_IDX-1:0]  trapReg,
  input  logic                msrLd,
  input  logic [XLEN-1:0]     msrLdVal,
  output logic                flush,
  output logic [XLEN-1:0]     newPc,
  output logic                gprWe,
  output logic [REG_IDX-1:0]  gprAddr,
  output logic [XLEN-1:0]     gprData,
  output logic [XLEN-1:0]     msr,
  output logic [XLEN-1:0]     esr,
  output logic [XLEN-1:0]     ear,
  output logic [XLEN-1:0]     btr,
  output logic [FSR_W-1:0]    fsr
);

  trapStrobes_t strobe;

  trap_ctrl u_ctrl (
    .rst     (rst),
    .excReq  (excReq),
    .brkReq  (brkReq),
    .irqReq  (irqReq),
    .trapReq (trapReq),
    .msrLd   (msrLd),
    .msrIe   (msr[IE_BIT]),
    .msrBip  (msr[BIP_BIT]),
    .msrEip  (msr[EIP_BIT]),
    .strobe  (strobe)
  );

  trap_dpath #(
    .XLEN(XLEN), .REG_IDX(REG_IDX), .CAUSE_W(CAUSE_W), .DETAIL_W(DETAIL_W),
    .FSR_W(FSR_W), .RESET_MSR(RESET_MSR), .IE_BIT(IE_BIT), .BIP_BIT(BIP_BIT),
    .EE_BIT(EE_BIT), .EIP_BIT(EIP_BIT)
  ) u_dpath (
    .clk          (clk),
    .strobe       (strobe),
    .inDelaySlot  (inDelaySlot),
    .curPc        (curPc),
    .branchTarget (branchTarget),
    .excCause     (excCause),
    .excDetail    (excDetail),
    .excAddr      (excAddr),
    .excFsr       (excFsr),
    .trapReg      (trapReg),
    .msrLdVal     (msrLdVal),
    .flush        (flush),
    .newPc        (newPc),
    .gprWe        (gprWe),
    .gprAddr      (gprAddr),
    .gprData      (gprData),
    .msr          (msr),
    .esr          (esr),
    .ear          (ear),
    .btr          (btr),
    .fsr          (fsr)
  );

endmodule

// File: rtl/trap_vector_unit_chk.sv
module trap_vector_unit_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned REG_IDX = 5,
  parameter int unsigned IE_BIT  = 1,
  parameter int unsigned BIP_BIT = 3,
  parameter int unsigned EE_BIT  = 8,
  parameter int unsigned EIP_BIT = 9
)(
  input logic               clk,
  input logic               rst,
  input logic               excReq,
  input logic               brkReq,
  input logic               irqReq,
  input logic               trapReq,
  input logic               msrLd,
  input logic               inDelaySlot,
  input logic [XLEN-1:0]    branchTarget,
  input logic               flush,
  input logic [XLEN-1:0]    newPc,
  input logic               gprWe,
  input logic [REG_IDX-1:0] gprAddr,
  input logic [XLEN-1:0]    msr,
  input logic [XLEN-1:0]    esr,
  input logic [XLEN-1:0]    ear,
  input logic [XLEN-1:0]    btr
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> flush && newPc == '0 && esr == '0 && ear == '0 && btr == '0);

  // R11
  gpr_only_on_flush_chk: assert property (@(posedge clk) disable iff (rst)
    gprWe |-> flush);

  // R7
  exc_status_chk: assert property (@(posedge clk) disable iff (rst)
    $past(excReq) && !$past(rst) |-> flush && newPc == XLEN'(32) && msr[EIP_BIT] && !msr[EE_BIT]);

  // R6
  brk_link_chk: assert property (@(posedge clk) disable iff (rst)
    $past(brkReq) && !$past(rst) && !$past(excReq)
      |-> gprWe && gprAddr == REG_IDX'(16) && msr[BIP_BIT]);

  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(irqReq) && !$past(msr[IE_BIT]) && !$past(rst || excReq || brkReq || trapReq)
      |-> !flush);

  // R9
  ds_target_chk: assert property (@(posedge clk) disable iff (rst)
    $past(excReq && inDelaySlot) && !$past(rst) |-> !gprWe && btr == $past(branchTarget));

  // R12
  msr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flush && !$past(msrLd) |-> $stable(msr));

endmodule

bind trap_vector_unit trap_vector_unit_chk #(
  .XLEN(XLEN), .REG_IDX(REG_IDX), .IE_BIT(IE_BIT), .BIP_BIT(BIP_BIT),
  .EE_BIT(EE_BIT), .EIP_BIT(EIP_BIT)
) u_chk (
  .clk(clk), .rst(rst), .excReq(excReq), .brkReq(brkReq), .irqReq(irqReq),
  .trapReq(trapReq), .msrLd(msrLd), .inDelaySlot(inDelaySlot),
  .branchTarget(branchTarget), .flush(flush), .newPc(newPc), .gprWe(gprWe),
  .gprAddr(gprAddr), .msr(msr), .esr(esr), .ear(ear), .btr(btr)
);

// File: tb/trap_vector_unit_test.sv
`timescale 1ns/1ps
module trap_vector_unit_test;

  localparam logic [31:0] RST_MSR = 32'h0000_0102;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        excReq = 1'b0, brkReq = 1'b0, irqReq = 1'b0, trapReq = 1'b0;
  logic        inDelaySlot = 1'b0;
  logic [31:0] curPc = '0, branchTarget = '0, excAddr = '0, msrLdVal = '0;
  logic [4:0]  excCause = '0, excFsr = '0, trapReg = '0;
  logic [6:0]  excDetail = '0;
  logic        msrLd = 1'b0;

  logic        flush, gprWe;
  logic [31:0] newPc, gprData, msr, esr, ear, btr;
  logic [4:0]  gprAddr, fsr;

  typedef struct {
    string       tag;
    logic        flush;
    logic [31:0] newPc;
    logic        gprWe;
    logic [4:0]  gprAddr;
    logic [31:0] gprData;
    logic [31:0] msr, esr, ear, btr;
    logic [4:0]  fsr;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mMsr = '0, mEsr = '0, mEar = '0, mBtr = '0;
  logic [4:0]  mFsr = '0;

  always #2 clk = ~clk;

  trap_vector_unit uut (
    .clk(clk), .rst(rst), .excReq(excReq), .brkReq(brkReq), .irqReq(irqReq),
    .trapReq(trapReq), .inDelaySlot(inDelaySlot), .curPc(curPc),
    .branchTarget(branchTarget), .excCause(excCause), .excDetail(excDetail),
    .excAddr(excAddr), .excFsr(excFsr), .trapReg(trapReg), .msrLd(msrLd),
    .msrLdVal(msrLdVal), .flush(flush), .newPc(newPc), .gprWe(gprWe),
    .gprAddr(gprAddr), .gprData(gprData), .msr(msr), .esr(esr), .ear(ear),
    .btr(btr), .fsr(fsr)
  );

  task automatic step(input bit r, input bit e, input bit b, input bit i,
                      input bit t, input bit ds, input bit ld,
                      input logic [31:0] ldVal, input logic [31:0] pc,
                      input string tag);
    expItem_t x;
    @(negedge clk);
    rst = r; excReq = e; brkReq = b; irqReq = i; trapReq = t;
    inDelaySlot = ds; msrLd = ld; msrLdVal = ldVal; curPc = pc;
    branchTarget = pc + 32'h100;
    excCause  = 5'(pc >> 4) ^ 5'h15;
    excDetail = 7'(pc >> 2);
    excAddr   = ~pc;
    excFsr    = 5'(pc >> 8);
    trapReg   = 5'(pc >> 4);
    x.tag = tag; x.flush = 1'b0; x.newPc = '0; x.gprWe = 1'b0;
    x.gprAddr = '0; x.gprData = '0;
    if (r) begin
      x.flush = 1'b1; x.newPc = 32'h0;
      mMsr = RST_MSR; mEsr = '0; mEar = '0; mFsr = '0; mBtr = '0;
    end else if (e) begin
      x.flush = 1'b1; x.newPc = 32'h20;
      mMsr[8] = 1'b0; mMsr[9] = 1'b1;
      mEsr = {19'b0, ds, excDetail, excCause};
      mEar = excAddr; mFsr = excFsr;
      if (ds) mBtr = branchTarget;
      else begin x.gprWe = 1'b1; x.gprAddr = 5'd17; x.gprData = pc + 32'd4; end
    end else if (b) begin
      x.flush = 1'b1; x.newPc = 32'h18; mMsr[3] = 1'b1;
      x.gprWe = 1'b1; x.gprAddr = 5'd16; x.gprData = pc;
    end else if (i && mMsr[1] && !mMsr[3] && !mMsr[9]) begin
      x.flush = 1'b1; x.newPc = 32'h10; mMsr[1] = 1'b0;
      x.gprWe = 1'b1; x.gprAddr = 5'd14; x.gprData = pc;
    end else if (t) begin
      x.flush = 1'b1; x.newPc = 32'h08;
      x.gprWe = 1'b1; x.gprAddr = trapReg; x.gprData = pc;
    end else if (ld) begin
      mMsr = ldVal;
    end
    x.msr = mMsr; x.esr = mEsr; x.ear = mEar; x.btr = mBtr; x.fsr = mFsr;
    expQ.push_back(x);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t x;
        bit bad;
        x = expQ.pop_front();
        checks++;
        bad = (flush !== x.flush) || (x.flush && newPc !== x.newPc) ||
              (gprWe !== x.gprWe) ||
              (x.gprWe && (gprAddr !== x.gprAddr || gprData !== x.gprData)) ||
              (msr !== x.msr) || (esr !== x.esr) || (ear !== x.ear) ||
              (btr !== x.btr) || (fsr !== x.fsr);
        if (bad) begin
          fails++;
          $display("FAIL %s: got flush=%b pc=%h we=%b rd=%0d d=%h msr=%h esr=%h ear=%h btr=%h fsr=%h; exp flush=%b pc=%h we=%b rd=%0d d=%h msr=%h esr=%h ear=%h btr=%h fsr=%h",
                   x.tag, flush, newPc, gprWe, gprAddr, gprData, msr, esr, ear, btr, fsr,
                   x.flush, x.newPc, x.gprWe, x.gprAddr, x.gprData, x.msr, x.esr, x.ear, x.btr, x.fsr);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(1,0,0,0,0,0,0,'0,32'h0,    "R1 reset");
    step(1,0,0,0,0,0,0,'0,32'h0,    "R1 reset held");
    // R11 idle: no flush, nothing changes
    step(0,0,0,0,0,0,0,'0,32'h40,   "R11 idle");
    // R3 user trap, register index from trapReg
    step(0,0,0,0,1,0,0,'0,32'h100,  "R3 trap");
    step(0,0,0,0,0,0,0,'0,32'h104,  "R11 single pulse");
    // R4 accepted interrupt
    step(0,0,0,1,0,0,0,'0,32'h200,  "R4 irq");
    // R5 interrupt ignored while enable clear
    step(0,0,0,1,0,0,0,'0,32'h204,  "R5 irq masked");
    // R12 load msr when idle
    step(0,0,0,0,0,0,1,RST_MSR,32'h208, "R12 msr load");
    // R6 break
    step(0,0,1,0,0,0,0,'0,32'h300,  "R6 break");
    // R5 irq blocked by break-in-progress, trap taken instead
    step(0,0,0,1,1,0,0,'0,32'h340,  "R5 irq blocked trap wins");
    step(0,0,0,0,0,0,1,RST_MSR,32'h344, "R12 msr restore");
    // R7 R8 R10 exception outside delay slot
    step(0,1,0,0,0,0,0,'0,32'h400,  "R7 R8 R10 exc");
    // R12 load dropped when event taken; R2 break over load
    step(0,0,1,0,0,0,1,32'hFFFF_FFFF,32'h480, "R12 R2 load dropped");
    step(0,0,0,0,0,0,1,RST_MSR,32'h484, "R12 msr restore 2");
    // R9 exception in delay slot
    step(0,1,0,0,0,1,0,'0,32'h500,  "R9 delay slot exc");
    step(0,0,0,0,0,0,1,RST_MSR,32'h504, "R12 msr restore 3");
    // R2 all requests: exception wins
    step(0,1,1,1,1,0,0,'0,32'h600,  "R2 exc wins");
    step(0,0,0,0,0,0,1,RST_MSR,32'h604, "R12 msr restore 4");
    // R2 irq beats trap
    step(0,0,0,1,1,0,0,'0,32'h700,  "R2 irq over trap");
    // R2 break beats irq and trap
    step(0,0,1,1,1,0,0,'0,32'h740,  "R2 break over irq");
    // R2 R1 reset beats everything
    step(1,1,1,1,1,1,0,'0,32'h800,  "R2 reset wins");
    step(0,0,0,0,0,0,0,'0,32'h0,    "R11 idle after reset");
    step(0,0,0,0,0,0,0,'0,32'h0,    "R11 idle 2");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule